// File: doc/BRIEF.md
# Configuration CRC Safety Monitor

This block watches over a bank of configuration registers inside a device controller. Once software enables it, it runs an 8-bit CRC across the bank, one register per clock. It then compares the result with a reference byte that software has written. While the controller is in its diagnostic state, a mismatch latches a configuration error flag. Software can read that flag, but it cannot write it.

A latched configuration error can be cleared in only one way: a timed check of an EEPROM-shadow image. Software starts this check with a command bit. During the run the EEPROM error flag reads 1. If the image checks good, both error flags drop when the run ends. If software turns the configuration CRC off while the configuration error is still latched, the block asks the controller for the SAFE state, raises the EEPROM error flag and clears the enable bit. A bad EEPROM result also asks for SAFE. Both reset paths put every flag, enable and sequencer back to the same defaults: the asynchronous reset pin and the synchronous request that the controller issues when it enters its RESET state.

Top module: `cfgcrc_guard`

## Requirements
- R1: The CRC uses polynomial 0x07, starts at 0x00 and applies no final XOR. It covers the configuration registers at addresses 0 to CFG_REGS-1, taking them in ascending order, and its result is compared with the reference register at address CFG_REGS.
- R2: In the diagnostic state, writing 1 to enable (bit 0 of the control register at address CFG_REGS+1) while it is 0 starts a scan. If the result mismatches, bit 0 of the status register at address CFG_REGS+2 (configuration error) is 1 within CFG_REGS+1 cycles.
- R3: Outside the diagnostic state, a mismatching scan leaves the configuration error at 0.
- R4: Clearing the enable bit and then setting it again reruns the scan. With a matching reference the configuration error stays 0.
- R5: Writing enable to 0 while the configuration error is 1 raises safe_req and sets status bit 1 (EEPROM error). Control bit 0 then reads 0.
- R6: Writing enable to 0 while the configuration error is 0 leaves safe_req and the EEPROM error at 0.
- R7: Writing 1 to control bit 1 (check command; it always reads back as 0) starts an EEPROM run. From the next cycle the EEPROM error reads 1 for RUN_CYCLES cycles.
- R8: The CRC of the image data bytes 0 to EE_BYTES-1 is compared with the stored byte at EE_BYTES. When they match, both error flags are 0 once the run ends.
- R9: When they do not match, the EEPROM error stays 1 after the run and safe_req rises.
- R10: A check command written while a run is busy is ignored, so the run still ends RUN_CYCLES cycles after its own start.
- R11: Writes to the status register have no effect on either flag.
- R12: Either rst_n low or a one-cycle enter_reset returns the configuration bank, the reference, the control and status registers and safe_req to 0. It also aborts any run. A check started afterwards sets the EEPROM error exactly as after power-up.
- R13: safe_req, once set, stays 1 until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| enter_reset | input | 1 | Synchronous return to defaults when the controller enters RESET |
| diag_mode | input | 1 | High while the controller is in its diagnostic state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| ee_image | input | (EE_BYTES+1)*8 | EEPROM-shadow bytes; byte i at bits 8i+7:8i, stored CRC in the top byte |
| safe_req | output | 1 | Sticky request for the SAFE state |

## Verification
The assertions assume that RUN_CYCLES is larger than EE_BYTES, so the image scan ends before the run timer does. They also assume that ee_image holds still for the whole of a run. The bench loads each image before it issues the check command and leaves it alone until the run has ended. The bench drives enter_reset as a single-cycle pulse, never asserted together with a register write. It changes diag_mode only while no scan is in flight.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;
  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_CHK_BIT = 1;

  // One register's worth of CRC8: fold the byte in, then eight shift/reduce steps.
  function automatic logic [7:0] crc8_byte(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] c;
    c = acc ^ din;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/cfgcrc_scan.sv
module cfgcrc_scan #(
  parameter int unsigned N_BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 start,
  input  logic                 abort,
  input  logic [N_BYTES*8-1:0] bytes_flat,
  output logic                 busy,
  output logic                 done,
  output logic [7:0]           crc_out
);
  import cfgcrc_pkg::*;
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BYTES - 1);

  logic [7:0]       byte_arr [N_BYTES];
  logic [IDX_W-1:0] idx;
  logic [7:0]       acc;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_unpack
    assign byte_arr[g] = bytes_flat[g*8 +: 8];
  end

  assign crc_out = crc8_byte(acc, byte_arr[idx]);
  assign done    = busy && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      acc  <= '0;
    end else if (clr || abort) begin
      busy <= 1'b0;
      idx  <= '0;
      acc  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      acc  <= '0;
    end else if (busy) begin
      acc <= crc_out;
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgcrc_runtimer.sv
module cfgcrc_runtimer #(
  parameter int unsigned RUN_CYCLES = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(RUN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgcrc_regs.sv
module cfgcrc_regs #(
  parameter int unsigned CFG_REGS = 8,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [7:0]            ctrl_view,
  input  logic [7:0]            stat_view,
  output logic [CFG_REGS*8-1:0] cfg_flat,
  output logic [7:0]            ref_crc,
  output logic [7:0]            rd_data
);
  localparam logic [ADDR_W-1:0] REF_ADDR  = ADDR_W'(CFG_REGS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CFG_REGS + 1);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(CFG_REGS + 2);

  logic [7:0] bank [CFG_REGS];

  for (genvar g = 0; g < CFG_REGS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    bank[g] <= '0;
      else if (clr)                                  bank[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))       bank[g] <= wr_data;
    end
    assign cfg_flat[g*8 +: 8] = bank[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ref_crc <= '0;
    else if (clr)                            ref_crc <= '0;
    else if (wr_en && wr_addr == REF_ADDR)   ref_crc <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == REF_ADDR)       rd_data = ref_crc;
    else if (rd_addr == CTRL_ADDR) rd_data = ctrl_view;
    else if (rd_addr == STAT_ADDR) rd_data = stat_view;
    else begin
      for (int i = 0; i < CFG_REGS; i++) begin
        if (rd_addr == ADDR_W'(i)) rd_data = bank[i];
      end
    end
  end
endmodule

// File: rtl/cfgcrc_guard.sv
module cfgcrc_guard #(
  parameter int unsigned CFG_REGS   = 8,
  parameter int unsigned EE_BYTES   = 16,
  parameter int unsigned RUN_CYCLES = 32000,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enter_reset,
  input  logic                    diag_mode,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  input  logic [(EE_BYTES+1)*8-1:0] ee_image,
  output logic                    safe_req
);
  import cfgcrc_pkg::*;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CFG_REGS + 1);

  // named internal events
  logic ctrl_wr, en_rise, en_fall, disable_with_err, ee_cmd, ee_start;
  logic cfg_scan_busy, cfg_scan_done, cfg_mismatch;
  logic ee_scan_busy, ee_scan_done, ee_busy, ee_run_done, ee_good;
  logic [7:0] cfg_crc, ee_crc, ee_crc_q, ref_crc, ee_stored;
  logic [CFG_REGS*8-1:0] cfg_flat;
  logic cfg_en_q, cfg_err_q, ee_err_q;
  logic [7:0] ctrl_view, stat_view;

  assign ctrl_wr          = wr_en && (wr_addr == CTRL_ADDR);
  assign en_rise          = ctrl_wr &&  wr_data[CTL_EN_BIT] && !cfg_en_q;
  assign en_fall          = ctrl_wr && !wr_data[CTL_EN_BIT] &&  cfg_en_q;
  assign disable_with_err = en_fall && cfg_err_q;
  assign ee_cmd           = ctrl_wr && wr_data[CTL_CHK_BIT];
  assign ee_start         = ee_cmd && !ee_busy;
  assign cfg_mismatch     = (cfg_crc != ref_crc);
  assign ee_stored        = ee_image[EE_BYTES*8 +: 8];
  assign ee_good          = (ee_crc_q == ee_stored);

  assign ctrl_view = {6'b0, 1'b0, cfg_en_q};
  assign stat_view = {6'b0, ee_err_q, cfg_err_q};

  cfgcrc_regs #(.CFG_REGS(CFG_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(enter_reset),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .ctrl_view(ctrl_view), .stat_view(stat_view),
    .cfg_flat(cfg_flat), .ref_crc(ref_crc), .rd_data(rd_data)
  );

  cfgcrc_scan #(.N_BYTES(CFG_REGS)) u_cfg_scan (
    .clk(clk), .rst_n(rst_n), .clr(enter_reset), .start(en_rise), .abort(en_fall),
    .bytes_flat(cfg_flat), .busy(cfg_scan_busy), .done(cfg_scan_done), .crc_out(cfg_crc)
  );

  cfgcrc_scan #(.N_BYTES(EE_BYTES)) u_ee_scan (
    .clk(clk), .rst_n(rst_n), .clr(enter_reset), .start(ee_start), .abort(1'b0),
    .bytes_flat(ee_image[EE_BYTES*8-1:0]), .busy(ee_scan_busy), .done(ee_scan_done),
    .crc_out(ee_crc)
  );

  cfgcrc_runtimer #(.RUN_CYCLES(RUN_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(enter_reset), .start(ee_start),
    .busy(ee_busy), .done(ee_run_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ee_crc_q <= '0;
    else if (enter_reset)     ee_crc_q <= '0;
    else if (ee_scan_done)    ee_crc_q <= ee_crc;
  end

  // Flag updates; later statements take priority within one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q  <= 1'b0;
      cfg_err_q <= 1'b0;
      ee_err_q  <= 1'b0;
      safe_req  <= 1'b0;
    end else if (enter_reset) begin
      cfg_en_q  <= 1'b0;
      cfg_err_q <= 1'b0;
      ee_err_q  <= 1'b0;
      safe_req  <= 1'b0;
    end else begin
      if (ctrl_wr) cfg_en_q <= wr_data[CTL_EN_BIT];
      if (cfg_scan_done && !en_fall && diag_mode && cfg_mismatch) cfg_err_q <= 1'b1;
      if (ee_start) ee_err_q <= 1'b1;
      if (ee_run_done) begin
        if (ee_good) begin
          ee_err_q  <= 1'b0;
          cfg_err_q <= 1'b0;
        end else begin
          safe_req <= 1'b1;
        end
      end
      if (disable_with_err) begin
        safe_req <= 1'b1;
        ee_err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgcrc_guard_chk.sv
module cfgcrc_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic enter_reset,
  input logic diag_mode,
  input logic cfg_en_q,
  input logic cfg_err_q,
  input logic ee_err_q,
  input logic safe_req,
  input logic ee_busy,
  input logic ee_scan_busy,
  input logic cfg_scan_busy,
  input logic cfg_scan_done,
  input logic disable_with_err,
  input logic ee_run_done,
  input logic ee_good
);
  AST_EE_BUSY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ee_busy |-> ee_err_q); // R7
  AST_EE_SCAN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ee_scan_busy |-> ee_busy); // R7
  AST_CFG_SCAN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_scan_busy |-> cfg_en_q); // R4
  AST_NO_DIAG_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_err_q && !(cfg_scan_done && diag_mode)) |=> !cfg_err_q); // R3
  AST_DISABLE_TO_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_with_err && !enter_reset) |=> (safe_req && ee_err_q && !cfg_en_q)); // R5
  AST_GOOD_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_run_done && ee_good && !disable_with_err && !enter_reset) |=> (!ee_err_q && !cfg_err_q)); // R8
  AST_BAD_RUN_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_run_done && !ee_good && !enter_reset) |=> (safe_req && ee_err_q)); // R9
  AST_SAFE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_req && !enter_reset) |=> safe_req); // R13
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_reset |=> (!safe_req && !cfg_err_q && !ee_err_q && !ee_busy && !cfg_en_q)); // R12
endmodule

bind cfgcrc_guard cfgcrc_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enter_reset(enter_reset), .diag_mode(diag_mode),
  .cfg_en_q(cfg_en_q), .cfg_err_q(cfg_err_q), .ee_err_q(ee_err_q), .safe_req(safe_req),
  .ee_busy(ee_busy), .ee_scan_busy(ee_scan_busy), .cfg_scan_busy(cfg_scan_busy),
  .cfg_scan_done(cfg_scan_done), .disable_with_err(disable_with_err),
  .ee_run_done(ee_run_done), .ee_good(ee_good)
);

// File: tb/test_cfgcrc_guard.sv
module test_cfgcrc_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 8;
  localparam int NEE  = 6;
  localparam int RUN  = 40;
  localparam int AW   = 4;
  localparam logic [AW-1:0] A_REF  = AW'(NCFG);
  localparam logic [AW-1:0] A_CTRL = AW'(NCFG + 1);
  localparam logic [AW-1:0] A_STAT = AW'(NCFG + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_reset = 1'b0;
  logic diag_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [(NEE+1)*8-1:0] ee_image = '0;
  logic safe_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] cfg_m [NCFG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgcrc_guard #(.CFG_REGS(NCFG), .EE_BYTES(NEE), .RUN_CYCLES(RUN), .ADDR_W(AW)) i_cfgcrc_guard (
    .clk(clk), .rst_n(rst_n), .enter_reset(enter_reset), .diag_mode(diag_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ee_image(ee_image), .safe_req(safe_req)
  );

  // Bit-serial MSB-first CRC8, poly 0x07
  function automatic logic [7:0] serial_step(input logic [7:0] c_in, input logic [7:0] d);
    logic [7:0] c;
    logic fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic load_cfg(input int seed, output logic [7:0] crc);
    crc = 8'h00;
    for (int i = 0; i < NCFG; i++) begin
      cfg_m[i] = 8'((seed * 53 + i * 29 + 7) & 8'hFF);
      wr(AW'(i), cfg_m[i]);
      crc = serial_step(crc, cfg_m[i]);
    end
  endtask

  task automatic set_ee(input bit good);
    logic [7:0] c;
    logic [7:0] b;
    c = 8'h00;
    for (int i = 0; i < NEE; i++) begin
      b = 8'((i * 41 + 19) & 8'hFF);
      ee_image[i*8 +: 8] = b;
      c = serial_step(c, b);
    end
    ee_image[NEE*8 +: 8] = good ? c : (c ^ 8'h5A);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    hard_reset();
    rd(A_STAT, v); check("R12 status after reset", v, 8'h00);
    rd(A_CTRL, v); check("R12 ctrl after reset", v, 8'h00);
    check("R12 safe_req after reset", {7'b0, safe_req}, 8'h00);
  endtask

  task automatic t_mismatch_then_good_run();
    logic [7:0] crc, v;
    hard_reset();
    diag_mode = 1'b1;
    load_cfg(1, crc);
    wr(A_REF, crc ^ 8'h01);
    wr(A_CTRL, 8'h01);
    repeat (NCFG + 2) @(negedge clk);
    rd(A_STAT, v); check("R2 single-bit mismatch latches cfg error (R1)", v & 8'h01, 8'h01);
    set_ee(1'b1);
    wr(A_CTRL, 8'h03);
    rd(A_STAT, v); check("R7 ee error set at run start", v & 8'h02, 8'h02);
    rd(A_CTRL, v); check("R7 check command reads 0", v, 8'h01);
    repeat (RUN - 2) @(negedge clk);
    rd(A_STAT, v); check("R7 ee error held near end of run", v & 8'h02, 8'h02);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); check("R8 good run clears both flags", v, 8'h00);
    check("R8 no safe after good run", {7'b0, safe_req}, 8'h00);
  endtask

  task automatic t_match_rerun();
    logic [7:0] crc, v;
    hard_reset();
    diag_mode = 1'b1;
    load_cfg(5, crc);
    wr(A_REF, crc);
    wr(A_CTRL, 8'h01);
    repeat (NCFG + 2) @(negedge clk);
    rd(A_STAT, v); check("R1 matching crc leaves cfg error 0", v, 8'h00);
    wr(A_CTRL, 8'h00);
    @(negedge clk);
    check("R6 clean disable no safe", {7'b0, safe_req}, 8'h00);
    rd(A_STAT, v); check("R6 clean disable ee error 0", v, 8'h00);
    wr(A_CTRL, 8'h01);
    repeat (NCFG + 2) @(negedge clk);
    rd(A_STAT, v); check("R4 rerun with match keeps cfg error 0", v, 8'h00);
  endtask

  task automatic t_no_diag();
    logic [7:0] crc, v;
    hard_reset();
    diag_mode = 1'b0;
    load_cfg(9, crc);
    wr(A_REF, crc ^ 8'h80);
    wr(A_CTRL, 8'h01);
    repeat (NCFG + 2) @(negedge clk);
    rd(A_STAT, v); check("R3 mismatch outside diag ignored", v, 8'h00);
    diag_mode = 1'b1;
  endtask

  task automatic t_disable_with_err();
    logic [7:0] crc, v;
    hard_reset();
    diag_mode = 1'b1;
    load_cfg(3, crc);
    wr(A_REF, crc ^ 8'h10);
    wr(A_CTRL, 8'h01);
    repeat (NCFG + 2) @(negedge clk);
    wr(A_CTRL, 8'h00);
    check("R5 safe_req raised", {7'b0, safe_req}, 8'h01);
    rd(A_STAT, v); check("R5 ee error set, cfg error kept", v, 8'h03);
    rd(A_CTRL, v); check("R5 enable cleared", v, 8'h00);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); check("R11 status write ignored", v, 8'h03);
    wr(A_CTRL, 8'h01);
    repeat (NCFG + 2) @(negedge clk);
    check("R13 safe_req sticky", {7'b0, safe_req}, 8'h01);
  endtask

  task automatic t_ee_bad();
    logic [7:0] v;
    hard_reset();
    set_ee(1'b0);
    wr(A_CTRL, 8'h02);
    repeat (RUN + 2) @(negedge clk);
    rd(A_STAT, v); check("R9 bad image keeps ee error", v, 8'h02);
    check("R9 bad image raises safe", {7'b0, safe_req}, 8'h01);
  endtask

  task automatic t_ee_ignore();
    logic [7:0] v;
    hard_reset();
    set_ee(1'b1);
    wr(A_CTRL, 8'h02);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 8'h02);
    repeat (RUN - 10) @(negedge clk);
    rd(A_STAT, v); check("R10 command while busy ignored", v, 8'h00);
  endtask

  task automatic t_sync_reset_mid_run();
    logic [7:0] crc, v;
    hard_reset();
    diag_mode = 1'b1;
    load_cfg(7, crc);
    wr(A_REF, crc ^ 8'h04);
    wr(A_CTRL, 8'h01);
    repeat (NCFG + 2) @(negedge clk);
    set_ee(1'b1);
    wr(A_CTRL, 8'h03);
    repeat (5) @(negedge clk);
    enter_reset = 1'b1;
    @(negedge clk);
    enter_reset = 1'b0;
    rd(A_STAT, v); check("R12 sync reset clears flags", v, 8'h00);
    rd(A_CTRL, v); check("R12 sync reset clears enable", v, 8'h00);
    rd(A_REF, v);  check("R12 sync reset clears reference", v, 8'h00);
    rd(AW'(0), v); check("R12 sync reset clears config bank", v, 8'h00);
    wr(A_CTRL, 8'h02);
    rd(A_STAT, v); check("R12 new run flagged after sync reset", v, 8'h02);
    repeat (RUN + 2) @(negedge clk);
    rd(A_STAT, v); check("R12 new run completes after sync reset", v, 8'h00);
    check("R12 no safe after sync reset run", {7'b0, safe_req}, 8'h00);
  endtask

  initial begin
    t_reset_state();
    t_mismatch_then_good_run();
    t_match_rerun();
    t_no_diag();
    t_disable_with_err();
    t_ee_bad();
    t_ee_ignore();
    t_sync_reset_mid_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule